// File: doc/BRIEF.md
# Instrument Status Reporting Register Set

This block keeps the status-reporting state of an instrument's remote-control interface. The instrument core raises single-cycle event pulses. Each pulse sets a sticky bit in one of two event registers. The first is an 8-bit standard event register with a per-bit enable mask. The second is an instrument-specific event register with its own enable mask. From these registers and a message-available input, the block builds an 8-bit status byte. It also drives a service request line, gated by a service request enable mask.

A host reaches the registers through a small request port. The host presents a request with a 3-bit address and a read/write flag. The port is driven by a two-state access machine with states ACC_IDLE and ACC_RESP:

- In ACC_IDLE the port is ready. A write takes effect in the cycle it is accepted, and the machine stays in ACC_IDLE.
- An accepted read takes the transition IDLE_TO_RESP. The read data is captured in that same cycle.
- In ACC_RESP the captured data is presented with a valid strobe for one cycle, and the port is not ready. The machine then always takes the transition RESP_TO_IDLE.

Reading either event register clears it. A clear-status command empties both event registers and leaves the masks alone.

Top module: `status_report_regs`

## Requirements
- R1: The status byte carries the instrument summary in bit 0, message-available in bit 4, the event summary in bit 5 and the request-service bit in bit 6. Bits 1, 2, 3 and 7 always read 0.
- R2: Status byte bit 0 is the OR over all bits of (instrument event register AND instrument enable mask), evaluated from the values present in the cycle the status byte is read. The instrument event register is sticky and clears when it is read.
- R3: Each event register bit is sticky. It stays 1 until the register is read (address 1) or clear-status is issued. A read returns the value held before the clear.
- R4: A pulse on bit k of the event input sets bit k of the event register. Bit 3 is the device-dependent error.
- R5: The event summary (status bit 5) sets only in a cycle where an event register bit enabled by the event enable mask goes from 0 to 1. Enabling a mask bit for an already-set bit, or re-pulsing a set bit, does not set it.
- R6: Reading the event register or issuing clear-status returns the event summary to 0, unless an enabled event arrives in that same cycle.
- R7: The request-service bit is the OR of (status byte AND service request mask) over bit positions 1 to 5 and 7. Mask bits 0 and 6 have no effect.
- R8: The service request output equals the request-service bit.
- R9: Writing any value to address 6 (clear-status) zeroes both event registers and the event summary. The three masks keep their values.
- R10: An event pulse in the same cycle as a clear (read or clear-status) of its register survives. It appears on the next read and can set the summary.
- R11: After reset every register is 0. The status byte reads 0 and the service request output is low until a mask is written.
- R12: The address map is 0 for the status byte (read), 1 for the event register (read), 2 for the event enable mask, 3 for the instrument register (read), 4 for the instrument mask, 5 for the service request mask, and 6 for clear-status (write). Masks read back what was written. Read data appears with the valid strobe for exactly one cycle, starting the cycle after acceptance, and ready is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| esr_evt_i | input | EVT_W | Event pulses for the standard event register |
| ins_evt_i | input | INS_W | Event pulses for the instrument event register |
| mav_i | input | 1 | Message-available flag from the output queue |
| host_req_i | input | 1 | Host access request |
| host_wr_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 3 | Register address |
| host_wdata_i | input | 8 | Write data |
| host_ready_o | output | 1 | Port can accept a request |
| host_rvalid_o | output | 1 | Read data valid (one cycle) |
| host_rdata_o | output | 8 | Read data |
| srq_o | output | 1 | Service request line |

## Verification
The bench builds the block with both event widths at their default of 8. This brings the device-error bit 3 and the top instrument bit 7 into reach. It also allows a status byte with every summary bit set at once, so the zero-padded positions can be checked against fully populated neighbours.

With full 8-bit masks, the bench can write a service request mask of all ones or only bit 6. It can also place event pulses in the same cycle as a clear-on-read or a clear-status command. This exercises the merge of events with clears and the edge-only rule for the event summary.

// File: rtl/status_rpt_pkg.sv
package status_rpt_pkg;

    localparam int STB_W        = 8;
    localparam int ADDR_W       = 3;
    localparam int STB_IEB_BIT  = 0;
    localparam int STB_MAV_BIT  = 4;
    localparam int STB_ESB_BIT  = 5;
    localparam int STB_RQS_BIT  = 6;
    // positions that feed the request-service bit: 1..5 and 7
    localparam logic [STB_W-1:0] RQS_SRC_MASK = 8'hBE;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STB = 3'd0,
        ADR_ESR = 3'd1,
        ADR_ESE = 3'd2,
        ADR_IER = 3'd3,
        ADR_IEE = 3'd4,
        ADR_SRE = 3'd5,
        ADR_CLS = 3'd6,
        ADR_RSV = 3'd7
    } reg_addr_e;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    typedef struct packed {
        logic esr_clr;
        logic ier_clr;
        logic cls;
        logic ese_we;
        logic iee_we;
        logic sre_we;
    } host_ctl_t;

endpackage

// File: rtl/status_sticky_reg.sv
module status_sticky_reg #(
    parameter int W             = 8,
    parameter bit LATCH_SUMMARY = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] bits_o,
    output logic         summary_o
);

    logic [W-1:0] bits_q;
    logic [W-1:0] base;

    // a clear drops history first; events of the same cycle are merged after
    assign base = clr_i ? '0 : bits_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bits_q <= '0;
        end else begin
            bits_q <= base | evt_i;
        end
    end

    assign bits_o = bits_q;

    generate
        if (LATCH_SUMMARY) begin : g_latched
            logic sum_q;
            logic rise;
            assign rise = |(evt_i & ~base & mask_i);
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    sum_q <= 1'b0;
                end else begin
                    sum_q <= (clr_i ? 1'b0 : sum_q) | rise;
                end
            end
            assign summary_o = sum_q;
        end else begin : g_level
            assign summary_o = |(bits_q & mask_i);
        end
    endgenerate

endmodule

// File: rtl/status_mask_regs.sv
module status_mask_regs
    import status_rpt_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int INS_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  host_ctl_t        ctl_i,
    input  logic [STB_W-1:0] wdata_i,
    output logic [EVT_W-1:0] ese_o,
    output logic [INS_W-1:0] iee_o,
    output logic [STB_W-1:0] sre_o
);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ese_o <= '0;
            iee_o <= '0;
            sre_o <= '0;
        end else begin
            if (ctl_i.ese_we) ese_o <= wdata_i[EVT_W-1:0];
            if (ctl_i.iee_we) iee_o <= wdata_i[INS_W-1:0];
            if (ctl_i.sre_we) sre_o <= wdata_i;
        end
    end

endmodule

// File: rtl/status_byte_build.sv
module status_byte_build
    import status_rpt_pkg::*;
(
    input  logic             ieb_i,
    input  logic             mav_i,
    input  logic             esb_i,
    input  logic [STB_W-1:0] sre_i,
    output logic [STB_W-1:0] stb_o,
    output logic             rqs_o
);

    logic [STB_W-1:0] base;

    always_comb begin
        base              = '0;
        base[STB_IEB_BIT] = ieb_i;
        base[STB_MAV_BIT] = mav_i;
        base[STB_ESB_BIT] = esb_i;
    end

    assign rqs_o = |(base & sre_i & RQS_SRC_MASK);

    always_comb begin
        stb_o              = base;
        stb_o[STB_RQS_BIT] = rqs_o;
    end

endmodule

// File: rtl/status_host_ctrl.sv
module status_host_ctrl
    import status_rpt_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int INS_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STB_W-1:0]  stb_i,
    input  logic [EVT_W-1:0]  esr_i,
    input  logic [EVT_W-1:0]  ese_i,
    input  logic [INS_W-1:0]  ier_i,
    input  logic [INS_W-1:0]  iee_i,
    input  logic [STB_W-1:0]  sre_i,
    output logic              ready_o,
    output logic              rvalid_o,
    output logic [STB_W-1:0]  rdata_o,
    output host_ctl_t         ctl_o
);

    acc_state_e       state_q, state_d;
    reg_addr_e        addr;
    logic             accept;
    logic [STB_W-1:0] rdata_d, rdata_q;
    logic [STB_W-1:0] esr_x, ese_x, ier_x, iee_x;

    assign addr = reg_addr_e'(addr_i);

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: IDLE_TO_RESP on an accepted read, RESP_TO_IDLE always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (req_i && !wr_i) state_d = ACC_RESP;
            ACC_RESP: state_d = ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    // outputs and decoded strobes
    always_comb begin
        ready_o  = (state_q == ACC_IDLE);
        rvalid_o = (state_q == ACC_RESP);
        accept   = ready_o && req_i;
        ctl_o    = '0;
        if (accept) begin
            if (wr_i) begin
                unique case (addr)
                    ADR_ESE: ctl_o.ese_we = 1'b1;
                    ADR_IEE: ctl_o.iee_we = 1'b1;
                    ADR_SRE: ctl_o.sre_we = 1'b1;
                    ADR_CLS: ctl_o.cls    = 1'b1;
                    default: ;
                endcase
            end else begin
                unique case (addr)
                    ADR_ESR: ctl_o.esr_clr = 1'b1;
                    ADR_IER: ctl_o.ier_clr = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        esr_x = '0; esr_x[EVT_W-1:0] = esr_i;
        ese_x = '0; ese_x[EVT_W-1:0] = ese_i;
        ier_x = '0; ier_x[INS_W-1:0] = ier_i;
        iee_x = '0; iee_x[INS_W-1:0] = iee_i;
    end

    always_comb begin
        unique case (addr)
            ADR_STB: rdata_d = stb_i;
            ADR_ESR: rdata_d = esr_x;
            ADR_ESE: rdata_d = ese_x;
            ADR_IER: rdata_d = ier_x;
            ADR_IEE: rdata_d = iee_x;
            ADR_SRE: rdata_d = sre_i;
            default: rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (accept && !wr_i) begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/status_report_regs.sv
module status_report_regs
    import status_rpt_pkg::*;
#(
    parameter int EVT_W = 8,   // at most 8
    parameter int INS_W = 8    // at most 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [EVT_W-1:0]  esr_evt_i,
    input  logic [INS_W-1:0]  ins_evt_i,
    input  logic              mav_i,
    input  logic              host_req_i,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [STB_W-1:0]  host_wdata_i,
    output logic              host_ready_o,
    output logic              host_rvalid_o,
    output logic [STB_W-1:0]  host_rdata_o,
    output logic              srq_o
);

    host_ctl_t        ctl;
    logic             esr_clear, ier_clear;
    logic [EVT_W-1:0] esr_bits, ese_q;
    logic [INS_W-1:0] ier_bits, iee_q;
    logic [STB_W-1:0] sre_q, stb;
    logic             esb, ieb, rqs;

    assign esr_clear = ctl.esr_clr | ctl.cls;
    assign ier_clear = ctl.ier_clr | ctl.cls;

    status_host_ctrl #(.EVT_W(EVT_W), .INS_W(INS_W)) u_host (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (host_req_i),
        .wr_i     (host_wr_i),
        .addr_i   (host_addr_i),
        .stb_i    (stb),
        .esr_i    (esr_bits),
        .ese_i    (ese_q),
        .ier_i    (ier_bits),
        .iee_i    (iee_q),
        .sre_i    (sre_q),
        .ready_o  (host_ready_o),
        .rvalid_o (host_rvalid_o),
        .rdata_o  (host_rdata_o),
        .ctl_o    (ctl)
    );

    status_mask_regs #(.EVT_W(EVT_W), .INS_W(INS_W)) u_masks (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ctl_i   (ctl),
        .wdata_i (host_wdata_i),
        .ese_o   (ese_q),
        .iee_o   (iee_q),
        .sre_o   (sre_q)
    );

    status_sticky_reg #(.W(EVT_W), .LATCH_SUMMARY(1'b1)) u_esr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (esr_evt_i),
        .clr_i     (esr_clear),
        .mask_i    (ese_q),
        .bits_o    (esr_bits),
        .summary_o (esb)
    );

    status_sticky_reg #(.W(INS_W), .LATCH_SUMMARY(1'b0)) u_ier (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (ins_evt_i),
        .clr_i     (ier_clear),
        .mask_i    (iee_q),
        .bits_o    (ier_bits),
        .summary_o (ieb)
    );

    status_byte_build u_stb (
        .ieb_i (ieb),
        .mav_i (mav_i),
        .esb_i (esb),
        .sre_i (sre_q),
        .stb_o (stb),
        .rqs_o (rqs)
    );

    assign srq_o = rqs;

endmodule

// File: rtl/status_report_regs_chk.sv
module status_report_regs_chk #(
    parameter int EVT_W = 8,
    parameter int INS_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [EVT_W-1:0] esr_evt_i,
    input logic [INS_W-1:0] ins_evt_i,
    input logic [EVT_W-1:0] esr_bits,
    input logic [INS_W-1:0] ier_bits,
    input logic [EVT_W-1:0] ese_q,
    input logic [INS_W-1:0] iee_q,
    input logic [7:0]       sre_q,
    input logic [7:0]       stb,
    input logic             esb,
    input logic             esr_clear,
    input logic             cls,
    input logic             srq_o,
    input logic             host_ready_o,
    input logic             host_rvalid_o
);

    AST_STB_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb & 8'h8E) == 8'h00);  // R1

    AST_ESR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !esr_clear |=> ((esr_bits & $past(esr_bits)) == $past(esr_bits)));  // R3

    AST_ESR_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|esr_evt_i) |=> ((esr_bits & $past(esr_evt_i)) == $past(esr_evt_i)));  // R10

    AST_ESB_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(esb) |-> $past(|(esr_evt_i & ese_q)));  // R5

    AST_ESB_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (esr_clear && ((esr_evt_i & ese_q) == '0)) |=> !esb);  // R6

    AST_SRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sre_q & 8'h30) == 8'h00) |-> !srq_o);  // R7

    AST_CLS_KEEPS_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cls |=> ($stable(ese_q) && $stable(iee_q) && $stable(sre_q)));  // R9

    AST_CLS_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cls |=> ((esr_bits == $past(esr_evt_i)) && (ier_bits == $past(ins_evt_i))));  // R9

    AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_rvalid_o |=> !host_rvalid_o);  // R12

    AST_RVALID_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_rvalid_o |-> !host_ready_o);  // R12

endmodule

bind status_report_regs status_report_regs_chk #(.EVT_W(EVT_W), .INS_W(INS_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .esr_evt_i     (esr_evt_i),
    .ins_evt_i     (ins_evt_i),
    .esr_bits      (esr_bits),
    .ier_bits      (ier_bits),
    .ese_q         (ese_q),
    .iee_q         (iee_q),
    .sre_q         (sre_q),
    .stb           (stb),
    .esb           (esb),
    .esr_clear     (esr_clear),
    .cls           (ctl.cls),
    .srq_o         (srq_o),
    .host_ready_o  (host_ready_o),
    .host_rvalid_o (host_rvalid_o)
);

// File: tb/status_report_regs_tb.sv
`timescale 1ns/1ps
module status_report_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] esr_evt = '0;
    logic [7:0] ins_evt = '0;
    logic       mav = 1'b0;
    logic       req = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       ready, rvalid, srq;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    status_report_regs u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .esr_evt_i    (esr_evt),
        .ins_evt_i    (ins_evt),
        .mav_i        (mav),
        .host_req_i   (req),
        .host_wr_i    (wr),
        .host_addr_i  (addr),
        .host_wdata_i (wdata),
        .host_ready_o (ready),
        .host_rvalid_o(rvalid),
        .host_rdata_o (rdata),
        .srq_o        (srq)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%02h exp=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_esr, m_ese, m_ier, m_iee, m_sre, m_rd;
    bit         m_esb, m_busy;

    function automatic logic [7:0] m_stb();
        logic [7:0] s;
        s = 8'h00;
        if ((m_ier & m_iee) != 0) s = s | 8'h01;
        if (mav)   s = s | 8'h10;
        if (m_esb) s = s | 8'h20;
        if ((s & m_sre & 8'hBE) != 0) s = s | 8'h40;
        return s;
    endfunction

    always @(posedge clk) begin
        logic [7:0] base;
        bit clr_e, clr_i;
        if (!rst_n) begin
            m_esr = 0; m_ese = 0; m_ier = 0; m_iee = 0; m_sre = 0;
            m_rd = 0; m_esb = 0; m_busy = 0;
        end else begin
            clr_e = 0; clr_i = 0;
            if (m_busy) begin
                m_busy = 0;
                if (req && wr) $display("bench misuse: request while busy");
            end else if (req && !wr) begin
                m_busy = 1;
                case (addr)
                    3'd0: m_rd = m_stb();
                    3'd1: begin m_rd = m_esr; clr_e = 1; end
                    3'd2: m_rd = m_ese;
                    3'd3: begin m_rd = m_ier; clr_i = 1; end
                    3'd4: m_rd = m_iee;
                    3'd5: m_rd = m_sre;
                    default: m_rd = 0;
                endcase
            end else if (req && wr && addr == 3'd6) begin
                clr_e = 1; clr_i = 1;
            end
            base  = clr_e ? 8'h00 : m_esr;
            m_esb = (clr_e ? 1'b0 : m_esb) | ((esr_evt & ~base & m_ese) != 0);
            m_esr = base | esr_evt;
            m_ier = (clr_i ? 8'h00 : m_ier) | ins_evt;
            if (req && wr && !ready) ; // never issued by this bench
            else if (req && wr) begin
                case (addr)
                    3'd2: m_ese = wdata;
                    3'd4: m_iee = wdata;
                    3'd5: m_sre = wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(ready == !m_busy, "R12 ready", {7'd0, ready}, {7'd0, !m_busy});
            chk(rvalid == m_busy, "R12 rvalid", {7'd0, rvalid}, {7'd0, m_busy});
            if (m_busy) chk(rdata == m_rd, "R12 rdata", rdata, m_rd);
            chk(srq == m_stb()[6], "R8 srq", {7'd0, srq}, {7'd0, m_stb()[6]});
        end
    end

    task automatic op(input bit rq, input bit w, input logic [2:0] a, input logic [7:0] d,
                      input logic [7:0] ev, input logic [7:0] iv, output logic [7:0] rd);
        @(posedge clk); #1;
        req = rq; wr = w; addr = a; wdata = d; esr_evt = ev; ins_evt = iv;
        @(posedge clk); #1;
        req = 0; wr = 0; esr_evt = 0; ins_evt = 0;
        rd = rdata;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        op(1, 0, a, 8'h00, 8'h00, 8'h00, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] v;
        op(1, 1, a, d, 8'h00, 8'h00, v);
    endtask

    task automatic pulse(input logic [7:0] ev, input logic [7:0] iv);
        logic [7:0] v;
        op(0, 0, 3'd0, 8'h00, ev, iv, v);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(srq == 1'b0, "R11 srq after reset", {7'd0, srq}, 8'h00);
        rd_chk(3'd0, 8'h00, "R11 status byte after reset");
        rd_chk(3'd2, 8'h00, "R11 enable mask after reset");

        wr_reg(3'd2, 8'h08);
        rd_chk(3'd2, 8'h08, "R12 enable mask readback");
        wr_reg(3'd5, 8'h20);
        pulse(8'h08, 8'h00);
        rd_chk(3'd0, 8'h60, "R5 R1 summary and request set");
        chk(srq == 1'b1, "R8 srq high", {7'd0, srq}, 8'h01);
        rd_chk(3'd1, 8'h08, "R4 device error bit 3");
        rd_chk(3'd0, 8'h00, "R6 summary cleared by read");
        chk(srq == 1'b0, "R8 srq low", {7'd0, srq}, 8'h00);
        rd_chk(3'd1, 8'h00, "R3 cleared on read");

        pulse(8'h01, 8'h00);
        repeat (5) @(posedge clk);
        rd_chk(3'd0, 8'h00, "R5 unmasked event no summary");
        pulse(8'h01, 8'h00);
        rd_chk(3'd1, 8'h01, "R3 sticky bit");

        pulse(8'h01, 8'h00);
        wr_reg(3'd2, 8'h09);
        rd_chk(3'd0, 8'h00, "R5 enabling set bit no summary");
        pulse(8'h01, 8'h00);
        rd_chk(3'd0, 8'h00, "R5 re-pulse no edge");
        rd_chk(3'd1, 8'h01, "R3 read returns value");
        pulse(8'h01, 8'h00);
        rd_chk(3'd0, 8'h60, "R5 fresh edge sets summary");
        rd_chk(3'd1, 8'h01, "R6 clear via read");

        wr_reg(3'd4, 8'h04);
        pulse(8'h00, 8'h04);
        rd_chk(3'd0, 8'h01, "R2 instrument summary");
        wr_reg(3'd5, 8'h01);
        chk(srq == 1'b0, "R7 mask bit 0 no effect", {7'd0, srq}, 8'h00);
        wr_reg(3'd4, 8'h00);
        rd_chk(3'd0, 8'h00, "R2 recomputed from mask");
        rd_chk(3'd3, 8'h04, "R2 instrument register read");
        rd_chk(3'd3, 8'h00, "R2 instrument clear on read");

        mav = 1'b1;
        wr_reg(3'd5, 8'h10);
        chk(srq == 1'b1, "R7 message available request", {7'd0, srq}, 8'h01);
        wr_reg(3'd5, 8'h40);
        chk(srq == 1'b0, "R7 mask bit 6 ignored", {7'd0, srq}, 8'h00);
        rd_chk(3'd0, 8'h10, "R1 message available bit 4");
        wr_reg(3'd5, 8'hFF);
        pulse(8'h08, 8'h80);
        wr_reg(3'd4, 8'hFF);
        op(1, 0, 3'd0, 8'h00, 8'h00, 8'h00, v);
        chk(v == 8'h71, "R1 full status byte", v, 8'h71);
        chk((v & 8'h8E) == 8'h00, "R1 unused bits zero", v & 8'h8E, 8'h00);

        wr_reg(3'd6, 8'hA5);
        rd_chk(3'd1, 8'h00, "R9 event register cleared");
        rd_chk(3'd3, 8'h00, "R9 instrument register cleared");
        rd_chk(3'd0, 8'h50, "R9 summary cleared");
        rd_chk(3'd2, 8'h09, "R9 event mask kept");
        rd_chk(3'd4, 8'hFF, "R9 instrument mask kept");
        rd_chk(3'd5, 8'hFF, "R9 request mask kept");
        mav = 1'b0;

        pulse(8'h02, 8'h00);
        op(1, 0, 3'd1, 8'h00, 8'h04, 8'h00, v);
        chk(v == 8'h02, "R10 read returns old value", v, 8'h02);
        rd_chk(3'd1, 8'h04, "R10 event during read kept");
        pulse(8'h00, 8'h01);
        op(1, 0, 3'd3, 8'h00, 8'h00, 8'h10, v);
        chk(v == 8'h01, "R10 instrument read old value", v, 8'h01);
        rd_chk(3'd3, 8'h10, "R10 instrument event kept");
        op(1, 1, 3'd6, 8'h00, 8'h08, 8'h00, v);
        rd_chk(3'd0, 8'h60, "R10 event during clear-status sets summary");
        rd_chk(3'd1, 8'h08, "R10 event during clear-status kept");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule